// File: doc/BRIEF.md
# Double-Pumped Serial Link Frame Receiver

This block sits on the codec side of a serial audio link. It receives a bit clock, a sync line and one serial data line. Each line is sampled on both clock edges, so every bit-clock cycle carries two bit slots and a 48 kHz frame holds 1000 slots. A frame opens with an 8-slot high pulse on the sync line. The 32-bit command word follows on the data line, and it is delivered as a parallel word with a one-cycle strobe.

The sync line also carries stream tags. A tag is 8 slots long: a fixed 4-bit preamble and then a 4-bit stream ID. A tag opens the stream whose data starts in the slot right after the tag. The receiver is programmed with one stream ID, a sample width, a channel count and a block count (blocks per frame, 1 for 48 kHz, n for n times 48 kHz). Tags for that ID are followed, and their samples are delivered in parallel, right-justified, each with a strobe and a channel index. All other streams are skipped.

Internally, a dual-edge capture pair turns each bit-clock cycle into an ordered slot pair, with the rising-edge slot first. Two FSMs consume both slots of the pair in one rising-edge step. The sync decoder has states SY_IDLE and SY_GATHER. From SY_IDLE, a high sync slot moves it to SY_GATHER. After the eighth slot it returns to SY_IDLE and reports a frame event or a tag event. The receive FSM has states RX_WAIT, RX_CMD and RX_STREAM. A frame event moves it from any state to RX_CMD. A matching tag moves it from any state to RX_STREAM. RX_CMD returns to RX_WAIT after 32 bits. RX_STREAM returns to RX_WAIT after the last sample of the last block. An event affects the slot after the one in which it completes. A slot pair captured during bit-clock cycle k is processed at the next rising edge, so its strobes are visible in cycle k+1.

Top module: `link_frame_rx`

## Requirements
- R1: While rst_n is low, cmd_valid and smp_valid are 0 and both FSMs return to their idle states.
- R2: When the sync line is high for 8 consecutive slots, starting from the idle state, a frame starts. The next 32 data slots, most significant bit first, appear on cmd_word with cmd_valid high for exactly one cycle. The strobe follows the processing of the pair that holds the last bit.
- R3: Within each bit-clock cycle, the slot sampled on the rising edge comes before the slot sampled on the falling edge. A frame, a tag or a sample may begin in either slot.
- R4: A tag is 8 sync slots that begin with a high slot from the idle state: preamble 1010, then the 4-bit ID, most significant bit first. When the ID equals a non-zero cfg_stream_id, stream data starts in the following slot.
- R5: Each sample is cfg_width data slots, most significant bit first. It appears on smp_data right-justified, with zeros above bit cfg_width-1 and smp_valid high for one cycle. smp_chan counts 0 to cfg_chans-1 and then wraps to 0.
- R6: After a matching tag, exactly cfg_chans times cfg_blocks samples are delivered. Data slots after that are ignored until the next matching tag.
- R7: A tag with a different ID is ignored, and the data that follows it produces no strobe.
- R8: When cfg_stream_id is 0, no sample is ever delivered, and commands are still delivered.
- R9: A frame sync that completes during a stream ends the stream. A sample whose last slot is the final sync slot or earlier is still delivered. A partial sample is dropped.
- R10: cfg_width may be any value from 2 to MAX_W, odd values included. cfg_chans ranges from 1 to MAX_CH and cfg_blocks from 1 to MAX_BLK.
- R11: cmd_valid and smp_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; both edges carry a slot |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Sync line carrying frame pulses and stream tags |
| sdo_in | input | 1 | Serial data line |
| cfg_stream_id | input | 4 | Stream ID to forward; 0 selects none |
| cfg_width | input | WW_W | Sample width in bits |
| cfg_chans | input | CHC_W | Samples per block |
| cfg_blocks | input | BLC_W | Blocks per frame for the stream |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_word | output | 32 | Received command word |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_data | output | MAX_W | Right-justified sample |
| smp_chan | output | CH_W | Channel index of the sample |

## Verification
The bench goes after slot alignment: frames and tags that start on a falling-edge slot, and odd widths whose samples end alternately in rising and falling slots. A receiver that swapped the two slots of a pair would deliver bit-reversed pairs, and one that mis-timed event hand-over would shift every word by one bit. It writes more samples than the programmed count, tags for other IDs and ID 0, which expose a receiver that keeps running past its last block or matches the wrong stream. It also places a frame sync so that one sample ends exactly on the last sync slot. An off-by-one abort would either lose that sample or leak the following partial one.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
    localparam int CMD_BITS = 32;
    localparam int TAG_SLOTS = 8;
    localparam logic [3:0] TAG_PREAMBLE = 4'b1010;
    localparam logic [7:0] FRAME_MARK = 8'hFF;

    typedef enum logic { SY_IDLE, SY_GATHER } sync_state_e;
    typedef enum logic [1:0] { RX_WAIT, RX_CMD, RX_STREAM } rx_state_e;

    typedef struct packed {
        logic       frame;
        logic       tag;
        logic [3:0] id;
    } sync_ev_t;
endpackage

// File: rtl/link_edge_capture.sv
module link_edge_capture (
    input  logic       bclk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  logic       sdo_in,
    output logic [1:0] pair_data,
    output logic [1:0] pair_sync
);
    logic rise_d, rise_s, fall_d, fall_s;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            rise_d <= 1'b0;
            rise_s <= 1'b0;
        end else begin
            rise_d <= sdo_in;
            rise_s <= sync_in;
        end
    end

    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            fall_d <= 1'b0;
            fall_s <= 1'b0;
        end else begin
            fall_d <= sdo_in;
            fall_s <= sync_in;
        end
    end

    // index 0 is the earlier (rising-edge) slot
    assign pair_data = {fall_d, rise_d};
    assign pair_sync = {fall_s, rise_s};
endmodule

// File: rtl/link_sync_decoder.sv
module link_sync_decoder
    import link_rx_pkg::*;
(
    input  logic           bclk,
    input  logic           rst_n,
    input  logic [1:0]     pair_sync,
    output sync_ev_t [1:0] slot_ev
);
    sync_state_e st_q, st;
    logic [2:0]  cnt_q, cnt;
    logic [7:0]  sh_q, sh;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= SY_IDLE;
            cnt_q <= '0;
            sh_q  <= '0;
        end else begin
            st_q  <= st;
            cnt_q <= cnt;
            sh_q  <= sh;
        end
    end

    always_comb begin
        st      = st_q;
        cnt     = cnt_q;
        sh      = sh_q;
        slot_ev = '0;
        for (int i = 0; i < 2; i++) begin
            unique case (st)
                SY_IDLE: begin
                    if (pair_sync[i]) begin
                        st  = SY_GATHER;
                        sh  = 8'd1;
                        cnt = 3'd1;
                    end
                end
                SY_GATHER: begin
                    sh = {sh[6:0], pair_sync[i]};
                    if (cnt == 3'(TAG_SLOTS - 1)) begin
                        st  = SY_IDLE;
                        cnt = '0;
                        if (sh == FRAME_MARK) begin
                            slot_ev[i].frame = 1'b1;
                        end else if (sh[7:4] == TAG_PREAMBLE) begin
                            slot_ev[i].tag = 1'b1;
                            slot_ev[i].id  = sh[3:0];
                        end
                    end else begin
                        cnt = cnt + 3'd1;
                    end
                end
                default: st = SY_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/link_stream_rx.sv
module link_stream_rx
    import link_rx_pkg::*;
#(
    parameter int MAX_W   = 32,
    parameter int MAX_CH  = 8,
    parameter int MAX_BLK = 4,
    localparam int WW_W   = $clog2(MAX_W + 1),
    localparam int CHC_W  = $clog2(MAX_CH + 1),
    localparam int BLC_W  = $clog2(MAX_BLK + 1),
    localparam int CH_W   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
    localparam int BLK_W  = (MAX_BLK > 1) ? $clog2(MAX_BLK) : 1
) (
    input  logic                  bclk,
    input  logic                  rst_n,
    input  logic [1:0]            pair_data,
    input  sync_ev_t [1:0]        slot_ev,
    input  logic [3:0]            cfg_stream_id,
    input  logic [WW_W-1:0]       cfg_width,
    input  logic [CHC_W-1:0]      cfg_chans,
    input  logic [BLC_W-1:0]      cfg_blocks,
    output logic                  cmd_valid,
    output logic [CMD_BITS-1:0]   cmd_word,
    output logic                  smp_valid,
    output logic [MAX_W-1:0]      smp_data,
    output logic [CH_W-1:0]       smp_chan
);
    localparam int SH_W  = (MAX_W > CMD_BITS) ? MAX_W : CMD_BITS;
    localparam int CNT_W = $clog2(SH_W);

    rx_state_e          st_q, st;
    logic [CNT_W-1:0]   cnt_q, cnt, last_bit;
    logic [SH_W-1:0]    sh_q, sh;
    logic [CH_W-1:0]    ch_q, ch, last_ch, ch_out;
    logic [BLK_W-1:0]   blk_q, blk, last_blk;
    sync_ev_t           pend_q, ev;
    logic [MAX_W-1:0]   width_mask, smp_word;
    logic [CMD_BITS-1:0] cmd_next;
    logic               cmd_hit, smp_hit, sel_on;

    assign sel_on   = (cfg_stream_id != 4'd0);
    assign last_bit = CNT_W'(cfg_width - WW_W'(1));
    assign last_ch  = CH_W'(cfg_chans - CHC_W'(1));
    assign last_blk = BLK_W'(cfg_blocks - BLC_W'(1));

    always_comb begin
        for (int b = 0; b < MAX_W; b++) begin
            width_mask[b] = (b < int'(cfg_width));
        end
    end

    // state register: slot-1 event is held for the next pair's first slot
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= RX_WAIT;
            cnt_q  <= '0;
            sh_q   <= '0;
            ch_q   <= '0;
            blk_q  <= '0;
            pend_q <= '0;
        end else begin
            st_q   <= st;
            cnt_q  <= cnt;
            sh_q   <= sh;
            ch_q   <= ch;
            blk_q  <= blk;
            pend_q <= slot_ev[1];
        end
    end

    always_comb begin
        st       = st_q;
        cnt      = cnt_q;
        sh       = sh_q;
        ch       = ch_q;
        blk      = blk_q;
        ev       = '0;
        cmd_hit  = 1'b0;
        smp_hit  = 1'b0;
        cmd_next = '0;
        smp_word = '0;
        ch_out   = '0;
        for (int i = 0; i < 2; i++) begin
            ev = (i == 0) ? pend_q : slot_ev[0];
            if (ev.frame) begin
                st  = RX_CMD;
                cnt = '0;
            end else if (ev.tag && sel_on && (ev.id == cfg_stream_id)) begin
                st  = RX_STREAM;
                cnt = '0;
                ch  = '0;
                blk = '0;
            end
            sh = {sh[SH_W-2:0], pair_data[i]};
            unique case (st)
                RX_WAIT: ;
                RX_CMD: begin
                    if (cnt == CNT_W'(CMD_BITS - 1)) begin
                        cmd_hit  = 1'b1;
                        cmd_next = sh[CMD_BITS-1:0];
                        st       = RX_WAIT;
                    end else begin
                        cnt = cnt + CNT_W'(1);
                    end
                end
                RX_STREAM: begin
                    if (cnt == last_bit) begin
                        smp_hit  = 1'b1;
                        smp_word = sh[MAX_W-1:0] & width_mask;
                        ch_out   = ch;
                        cnt      = '0;
                        if (ch == last_ch) begin
                            ch = '0;
                            if (blk == last_blk) st = RX_WAIT;
                            else blk = blk + BLK_W'(1);
                        end else begin
                            ch = ch + CH_W'(1);
                        end
                    end else begin
                        cnt = cnt + CNT_W'(1);
                    end
                end
                default: st = RX_WAIT;
            endcase
        end
    end

    // output register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_word  <= '0;
            smp_valid <= 1'b0;
            smp_data  <= '0;
            smp_chan  <= '0;
        end else begin
            cmd_valid <= cmd_hit;
            smp_valid <= smp_hit;
            if (cmd_hit) cmd_word <= cmd_next;
            if (smp_hit) begin
                smp_data <= smp_word;
                smp_chan <= ch_out;
            end
        end
    end
endmodule

// File: rtl/link_frame_rx.sv
module link_frame_rx #(
    parameter int MAX_W   = 32,
    parameter int MAX_CH  = 8,
    parameter int MAX_BLK = 4,
    localparam int WW_W   = $clog2(MAX_W + 1),
    localparam int CHC_W  = $clog2(MAX_CH + 1),
    localparam int BLC_W  = $clog2(MAX_BLK + 1),
    localparam int CH_W   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             sync_in,
    input  logic             sdo_in,
    input  logic [3:0]       cfg_stream_id,
    input  logic [WW_W-1:0]  cfg_width,
    input  logic [CHC_W-1:0] cfg_chans,
    input  logic [BLC_W-1:0] cfg_blocks,
    output logic             cmd_valid,
    output logic [31:0]      cmd_word,
    output logic             smp_valid,
    output logic [MAX_W-1:0] smp_data,
    output logic [CH_W-1:0]  smp_chan
);
    logic [1:0]                    pair_data, pair_sync;
    link_rx_pkg::sync_ev_t [1:0]   slot_ev;

    link_edge_capture u_cap (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .sdo_in    (sdo_in),
        .pair_data (pair_data),
        .pair_sync (pair_sync)
    );

    link_sync_decoder u_sync (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .pair_sync (pair_sync),
        .slot_ev   (slot_ev)
    );

    link_stream_rx #(
        .MAX_W   (MAX_W),
        .MAX_CH  (MAX_CH),
        .MAX_BLK (MAX_BLK)
    ) u_rx (
        .bclk          (bclk),
        .rst_n         (rst_n),
        .pair_data     (pair_data),
        .slot_ev       (slot_ev),
        .cfg_stream_id (cfg_stream_id),
        .cfg_width     (cfg_width),
        .cfg_chans     (cfg_chans),
        .cfg_blocks    (cfg_blocks),
        .cmd_valid     (cmd_valid),
        .cmd_word      (cmd_word),
        .smp_valid     (smp_valid),
        .smp_data      (smp_data),
        .smp_chan      (smp_chan)
    );
endmodule

// File: rtl/link_frame_rx_chk.sv
module link_frame_rx_chk #(
    parameter int MAX_W   = 32,
    parameter int MAX_CH  = 8,
    localparam int WW_W   = $clog2(MAX_W + 1),
    localparam int CHC_W  = $clog2(MAX_CH + 1),
    localparam int CH_W   = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
    input logic             bclk,
    input logic             rst_n,
    input logic [3:0]       cfg_stream_id,
    input logic [WW_W-1:0]  cfg_width,
    input logic [CHC_W-1:0] cfg_chans,
    input logic             cmd_valid,
    input logic             smp_valid,
    input logic [MAX_W-1:0] smp_data,
    input logic [CH_W-1:0]  smp_chan
);
    // R2: command strobe lasts one cycle
    p_cmd_pulse_r2: assert property (@(posedge bclk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R5: sample is right-justified to the programmed width
    p_justify_r5: assert property (@(posedge bclk) disable iff (!rst_n)
        smp_valid |-> ((smp_data >> cfg_width) == '0));

    // R5: channel index stays below the channel count
    p_chan_range_r5: assert property (@(posedge bclk) disable iff (!rst_n)
        smp_valid |-> (int'(smp_chan) < int'(cfg_chans)));

    // R8: stream ID 0 forwards nothing
    p_id0_quiet_r8: assert property (@(posedge bclk) disable iff (!rst_n)
        (cfg_stream_id == 4'd0) |-> !smp_valid);

    // R11: command and sample strobes never coincide
    p_excl_r11: assert property (@(posedge bclk) disable iff (!rst_n)
        !(cmd_valid && smp_valid));
endmodule

bind link_frame_rx link_frame_rx_chk #(
    .MAX_W  (MAX_W),
    .MAX_CH (MAX_CH)
) u_chk (
    .bclk          (bclk),
    .rst_n         (rst_n),
    .cfg_stream_id (cfg_stream_id),
    .cfg_width     (cfg_width),
    .cfg_chans     (cfg_chans),
    .cmd_valid     (cmd_valid),
    .smp_valid     (smp_valid),
    .smp_data      (smp_data),
    .smp_chan      (smp_chan)
);

// File: tb/link_frame_rx_test.sv
module link_frame_rx_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD = 40;
    localparam int MAX_W = 32, MAX_CH = 8, MAX_BLK = 4;
    localparam int NSLOT = 2400;
    localparam int NPAIR = NSLOT / 2;

    logic bclk = 1'b0, rst_n = 1'b0, sync_in = 1'b0, sdo_in = 1'b0;
    logic [3:0]  cfg_stream_id = '0;
    logic [5:0]  cfg_width = 6'd16;
    logic [3:0]  cfg_chans = 4'd1;
    logic [2:0]  cfg_blocks = 3'd1;
    logic        cmd_valid, smp_valid;
    logic [31:0] cmd_word;
    logic [MAX_W-1:0] smp_data;
    logic [2:0]  smp_chan;

    bit          sy_s [NSLOT];
    bit          dt_s [NSLOT];
    bit          e_cv [NPAIR];
    logic [31:0] e_cw [NPAIR];
    bit          e_sv [NPAIR];
    logic [31:0] e_sd [NPAIR];
    int          e_sc [NPAIR];
    int checks = 0, errors = 0;
    string req = "";

    always #(CLK_PERIOD/2) bclk = ~bclk;

    link_frame_rx #(.MAX_W(MAX_W), .MAX_CH(MAX_CH), .MAX_BLK(MAX_BLK)) uut (
        .bclk(bclk), .rst_n(rst_n), .sync_in(sync_in), .sdo_in(sdo_in),
        .cfg_stream_id(cfg_stream_id), .cfg_width(cfg_width),
        .cfg_chans(cfg_chans), .cfg_blocks(cfg_blocks),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan));

    function automatic logic [31:0] mkval(int seed, int idx);
        return 32'(seed) * 32'h9E3779B1 + 32'(idx + 1) * 32'h85EBCA6B;
    endfunction

    task automatic clear_model();
        for (int i = 0; i < NSLOT; i++) begin sy_s[i] = 0; dt_s[i] = 0; end
        for (int i = 0; i < NPAIR; i++) begin
            e_cv[i] = 0; e_sv[i] = 0; e_cw[i] = '0; e_sd[i] = '0; e_sc[i] = 0;
        end
    endtask

    task automatic put_frame(int s, logic [31:0] cmd);
        for (int i = 0; i < 8; i++) sy_s[s + i] = 1;
        for (int b = 0; b < 32; b++) dt_s[s + 8 + b] = cmd[31 - b];
        e_cv[(s + 39) / 2] = 1;
        e_cw[(s + 39) / 2] = cmd;
    endtask

    task automatic put_tag(int s, int id);
        logic [7:0] t;
        t = {4'b1010, 4'(id)};
        for (int i = 0; i < 8; i++) sy_s[s + i] = t[7 - i];
    endtask

    // n samples of cfg_width bits from slot s; expected only when selected,
    // within chans*blocks, and complete by slot cut
    task automatic put_stream(int s, int id, int n, int seed, int cut);
        int w, lim, last;
        logic [31:0] v, m;
        w   = int'(cfg_width);
        lim = int'(cfg_chans) * int'(cfg_blocks);
        m   = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        for (int k = 0; k < n; k++) begin
            v = mkval(seed, k);
            for (int b = 0; b < w; b++) dt_s[s + k*w + b] = v[w - 1 - b];
            last = s + k*w + w - 1;
            if (id == int'(cfg_stream_id) && id != 0 && k < lim && last <= cut) begin
                e_sv[last / 2] = 1;
                e_sd[last / 2] = v & m;
                e_sc[last / 2] = k % int'(cfg_chans);
            end
        end
    endtask

    task automatic compare(int p);
        if (e_cv[p] || cmd_valid) begin
            checks++;
            if (cmd_valid !== e_cv[p] || (e_cv[p] && cmd_word !== e_cw[p])) begin
                errors++;
                $display("FAIL %s command pair %0d: valid=%b word=%h expected valid=%b word=%h",
                         req, p, cmd_valid, cmd_word, e_cv[p], e_cw[p]);
            end
        end
        if (e_sv[p] || smp_valid) begin
            checks++;
            if (smp_valid !== e_sv[p] ||
                (e_sv[p] && (smp_data !== e_sd[p] || int'(smp_chan) != e_sc[p]))) begin
                errors++;
                $display("FAIL %s sample pair %0d: valid=%b data=%h chan=%0d expected valid=%b data=%h chan=%0d",
                         req, p, smp_valid, smp_data, smp_chan, e_sv[p], e_sd[p], e_sc[p]);
            end
        end
    endtask

    task automatic run_case();
        rst_n = 0; sync_in = 0; sdo_in = 0;
        repeat (3) @(posedge bclk);
        @(negedge bclk);
        checks++;   // R1: strobes low in reset
        if (cmd_valid !== 1'b0 || smp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset strobes: cmd=%b smp=%b expected 0 0", cmd_valid, smp_valid);
        end
        rst_n = 1;
        for (int k = 0; k < NPAIR + 2; k++) begin
            @(negedge bclk);
            if (k >= 2) compare(k - 2);
            #(CLK_PERIOD/4);
            sync_in = (2*k < NSLOT) ? sy_s[2*k] : 1'b0;
            sdo_in  = (2*k < NSLOT) ? dt_s[2*k] : 1'b0;
            @(posedge bclk);
            #(CLK_PERIOD/4);
            sync_in = (2*k + 1 < NSLOT) ? sy_s[2*k + 1] : 1'b0;
            sdo_in  = (2*k + 1 < NSLOT) ? dt_s[2*k + 1] : 1'b0;
        end
    endtask

    task automatic set_cfg(int id, int w, int ch, int blk);
        cfg_stream_id = 4'(id); cfg_width = 6'(w);
        cfg_chans = 4'(ch); cfg_blocks = 3'(blk);
    endtask

    initial begin
        repeat (150000) @(posedge bclk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R2 R4 R5 R7: selected stream 5 behind an ignored stream 6
        req = "R2 R4 R5 R7";
        set_cfg(5, 16, 2, 1); clear_model();
        put_frame(0, 32'hC0DE_1234);
        put_tag(32, 6);   put_stream(40, 6, 2, 11, NSLOT);
        put_tag(64, 5);   put_stream(72, 5, 2, 12, NSLOT);
        put_frame(1000, 32'h8000_0001);
        put_tag(1032, 5); put_stream(1040, 5, 2, 13, NSLOT);
        run_case();

        // R3 R10: odd start slot, odd sample width
        req = "R3 R10";
        set_cfg(3, 7, 1, 4); clear_model();
        put_frame(1, 32'h5A5A_F00F);
        put_tag(33, 3);   put_stream(41, 3, 4, 21, NSLOT);
        put_frame(1001, 32'hFFFF_FFFF);
        put_tag(1033, 3); put_stream(1041, 3, 4, 22, NSLOT);
        run_case();

        // R6 R5 R7: three channels, two blocks, extra samples ignored
        req = "R6 R5 R7";
        set_cfg(9, 20, 3, 2); clear_model();
        put_frame(0, 32'h0000_0001);
        put_tag(32, 9);  put_stream(40, 9, 8, 31, NSLOT);
        put_tag(300, 2); put_stream(308, 2, 3, 32, NSLOT);
        put_frame(1000, 32'h1357_9BDF);
        run_case();

        // R8: ID 0 selects nothing, commands still arrive
        req = "R8";
        set_cfg(0, 16, 2, 1); clear_model();
        put_frame(0, 32'hA5A5_0F0F);
        put_tag(32, 0);  put_stream(40, 0, 2, 41, NSLOT);
        put_tag(100, 5); put_stream(108, 5, 2, 42, NSLOT);
        put_frame(1000, 32'h0F0F_A5A5);
        run_case();

        // R9: frame sync cuts a stream; a sample ending on the last sync slot survives
        req = "R9";
        set_cfg(4, 24, 2, 4); clear_model();
        put_frame(0, 32'h2468_ACE0);
        put_tag(32, 4);  put_stream(40, 4, 8, 51, NSLOT);
        put_tag(880, 4); put_stream(888, 4, 8, 52, 1007);
        put_frame(1000, 32'hDEAD_BEEF);
        run_case();

        // R10 R11: full 32-bit width
        req = "R10 R11";
        set_cfg(1, 32, 1, 1); clear_model();
        put_frame(0, 32'h7654_3210);
        put_tag(32, 1);   put_stream(40, 1, 1, 61, NSLOT);
        put_frame(1001, 32'h0123_4567);
        put_tag(1033, 1); put_stream(1041, 1, 1, 62, NSLOT);
        run_case();

        // R10 R11 R5: width 2, back-to-back strobes, eight channels, four blocks
        req = "R10 R11 R5";
        set_cfg(7, 2, 8, 4); clear_model();
        put_frame(0, 32'h8421_1248);
        put_tag(32, 7);   put_stream(40, 7, 32, 71, NSLOT);
        put_frame(1000, 32'h3C3C_C3C3);
        run_case();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule